// File: doc/BRIEF.md
# Reloading Interval Timer with Byte-Wide Register Access

This block is a 16-bit down counter with its own 16-bit reload register (the latch). Both are reached over an 8-bit register bus with four byte addresses. Address 0 is counter-low, address 1 is counter-high, address 2 is latch-low and address 3 is latch-high. Counting advances only in cycles where `tick_en` is high, so a prescaler outside the block sets the tick rate.

The input `cont_mode` selects one of two modes:

- **Continuous (free-run):** the counter falls from the latch value through zero to 0xFFFF, then reloads.
- **Single-shot:** the timer signals its first expiry after a load, then keeps wrapping silently.

An expiry sets an interrupt flag and emits a one-cycle set pulse to the interrupt controller. The flag is cleared by any of these:

- the `flag_clr` request input;
- a read of counter-low;
- a write to counter-high;
- a write to latch-high.

The counter runs a small state machine with three states:

- **COUNT:** normal decrement. It is the state after reset and after every load.
- **UNDER:** the count sits at 0xFFFF after an expiry in continuous mode. The next tick reloads.
- **SPENT:** single-shot mode after its expiry. The count keeps decrementing and never reloads.

The transitions are:

- LOAD: a counter-high write moves any state to COUNT.
- EXPIRE_CONT: COUNT to UNDER on a tick at zero with `cont_mode`=1.
- EXPIRE_SHOT: COUNT to SPENT on a tick at zero with `cont_mode`=0.
- RELOAD: UNDER to COUNT on the next tick.
- WRAP: SPENT to SPENT on each tick.

Top module: `reload_timer`

## Requirements
- R1: A write to address 0 (counter-low) or address 2 (latch-low) replaces only the latch low byte. The live count is unchanged.
- R2: A write to address 1 (counter-high) stores the latch high byte and copies the whole new latch into the counter at the same edge. It also clears the flag and re-arms the timer in state COUNT.
- R3: A write to address 3 (latch-high) stores the latch high byte and clears the flag. It leaves the count unchanged.
- R4: `rdata` is registered. It shows, one cycle after a read request, the value from before that edge. A read of address 0 returns the count low byte and clears the flag. A read of address 1 returns the count high byte and leaves the flag unchanged.
- R5: Reads of addresses 2 and 3 return the latch low and high bytes.
- R6: In continuous mode (`cont_mode`=1) the count goes L, L-1, ..., 0, 0xFFFF, L. Consecutive expiries are therefore L+2 ticks apart.
- R7: An expiry is a tick applied while the count is zero in state COUNT. At the following edge the count becomes 0xFFFF. After that same edge `irq_flag` goes high and `flag_set` is high for exactly one cycle. The flag then holds until it is cleared.
- R8: In single-shot mode (`cont_mode`=0) only the first expiry after a load sets the flag. The counter then keeps decrementing through 0xFFFE, 0xFFFD, ... without reloading and without setting the flag again.
- R9: A reload uses the latch value present at the reload tick. A latch change made during a period therefore takes effect at the next reload.
- R10: After reset the latch and the count are 0xFFFF, the flag and the pulse are low, `rdata` is 0, and the state is COUNT.
- R11: While `tick_en` is low and no load occurs, the count holds.
- R12: `flag_clr` clears the flag. If an expiry falls in the same cycle as any clear source, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one tick per high cycle |
| cont_mode | input | 1 | 1 = continuous reload, 0 = single-shot |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| flag_clr | input | 1 | Flag clear request from the interrupt controller |
| irq_flag | output | 1 | Timer interrupt flag |
| flag_set | output | 1 | One-cycle pulse when the flag is set |

## Verification
Each output has its own latency:

- A write takes effect at the edge it is presented on.
- `rdata` and the flag effects of a read are visible one cycle after the read strobe.
- `irq_flag` and `flag_set` rise one cycle after the expiring tick.

The bench drives every stimulus on a falling edge and holds it for exactly one rising edge. It samples results at the next falling edge, so each check lands in the cycle where its result is due. Tick sequences are applied one tick at a time, except for the long single-shot wrap run. Each pulse is therefore tied to the exact tick count that caused it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        A_CNT_LO = 2'd0,
        A_CNT_HI = 2'd1,
        A_LAT_LO = 2'd2,
        A_LAT_HI = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_UNDER = 2'd1,
        ST_SPENT = 2'd2
    } run_state_e;

endpackage

// File: rtl/tmr_latch.sv
module tmr_latch
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [CNT_W/2-1:0] wdata,
    output logic [CNT_W-1:0]   latch_q,
    output logic [CNT_W-1:0]   latch_nxt,
    output logic               load_req,
    output logic               hi_clr
);
    localparam int HALF  = CNT_W / 2;
    localparam int LANES = 2;

    logic [LANES-1:0] lane_hit;

    assign lane_hit[0] = wr_en && (addr == A_CNT_LO || addr == A_LAT_LO);
    assign lane_hit[1] = wr_en && (addr == A_CNT_HI || addr == A_LAT_HI);
    assign load_req    = wr_en && (addr == A_CNT_HI);
    assign hi_clr      = wr_en && (addr == A_LAT_HI);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        always_comb begin
            latch_nxt[ln*HALF +: HALF] = lane_hit[ln] ? wdata
                                                      : latch_q[ln*HALF +: HALF];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                latch_q[ln*HALF +: HALF] <= '1;
            end else if (lane_hit[ln]) begin
                latch_q[ln*HALF +: HALF] <= wdata;
            end
        end
    end

    AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        lane_hit[0] && !lane_hit[1] |=> latch_q[CNT_W-1:HALF] == $past(latch_q[CNT_W-1:HALF])); // R1

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cont_mode,
    input  logic             load_req,
    input  logic [CNT_W-1:0] latch_q,
    input  logic [CNT_W-1:0] latch_nxt,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    run_state_e state, state_nxt;
    logic       at_zero;

    assign at_zero = (count == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_COUNT;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (load_req) begin
            state_nxt = ST_COUNT;
        end else if (tick_en) begin
            unique case (state)
                ST_COUNT: if (at_zero) state_nxt = cont_mode ? ST_UNDER : ST_SPENT;
                ST_UNDER: state_nxt = ST_COUNT;
                ST_SPENT: state_nxt = ST_SPENT;
                default:  state_nxt = ST_COUNT;
            endcase
        end
    end

    always_comb begin
        expire = tick_en && !load_req && (state == ST_COUNT) && at_zero;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= ALL_ONES;
        end else if (load_req) begin
            count <= latch_nxt;
        end else if (tick_en) begin
            unique case (state)
                ST_UNDER: count <= latch_q;
                ST_COUNT, ST_SPENT: count <= count - ONE;
                default:  count <= count;
            endcase
        end
    end

    AST_LOAD_TAKES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> count == latch_q); // R2
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en && !load_req |=> $stable(count)); // R11
    AST_RELOAD_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_UNDER && tick_en && !load_req |=> count == $past(latch_q)); // R9
    AST_EXPIRY_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> count == ALL_ONES); // R6
    AST_SPENT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SPENT && !load_req |=> state == ST_SPENT); // R8

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_any,
    output logic irq_flag,
    output logic flag_set
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            flag_set <= 1'b0;
        end else begin
            flag_set <= expire;
            if (expire)       irq_flag <= 1'b1;
            else if (clr_any) irq_flag <= 1'b0;
        end
    end

    AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq_flag && flag_set); // R7
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> !flag_set); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any && !expire |=> !irq_flag); // R12

endmodule

// File: rtl/tmr_rdport.sv
module tmr_rdport
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [1:0]         addr,
    input  logic [CNT_W-1:0]   count,
    input  logic [CNT_W-1:0]   latch_q,
    output logic [CNT_W/2-1:0] rdata,
    output logic               rd_clr
);
    localparam int HALF = CNT_W / 2;

    logic [HALF-1:0] mux;

    always_comb begin
        unique case (addr)
            A_CNT_LO: mux = count[HALF-1:0];
            A_CNT_HI: mux = count[CNT_W-1:HALF];
            A_LAT_LO: mux = latch_q[HALF-1:0];
            A_LAT_HI: mux = latch_q[CNT_W-1:HALF];
            default:  mux = '0;
        endcase
    end

    assign rd_clr = rd_en && (addr == A_CNT_LO);

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= mux;
    end

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R4

endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               cont_mode,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         addr,
    input  logic [CNT_W/2-1:0] wdata,
    output logic [CNT_W/2-1:0] rdata,
    input  logic               flag_clr,
    output logic               irq_flag,
    output logic               flag_set
);
    logic [CNT_W-1:0] latch_q, latch_nxt, count;
    logic             load_req, hi_clr, rd_clr, expire, clr_any;

    tmr_latch #(.CNT_W(CNT_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .latch_q(latch_q), .latch_nxt(latch_nxt), .load_req(load_req), .hi_clr(hi_clr)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cont_mode(cont_mode),
        .load_req(load_req), .latch_q(latch_q), .latch_nxt(latch_nxt),
        .count(count), .expire(expire)
    );

    tmr_rdport #(.CNT_W(CNT_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .count(count),
        .latch_q(latch_q), .rdata(rdata), .rd_clr(rd_clr)
    );

    assign clr_any = flag_clr || load_req || hi_clr || rd_clr;

    tmr_flag u_flag (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr_any(clr_any),
        .irq_flag(irq_flag), .flag_set(flag_set)
    );

    AST_RDLO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == A_CNT_LO && !expire |=> !irq_flag); // R4
    AST_RDHI_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == A_CNT_HI && !wr_en && !flag_clr && irq_flag |=> irq_flag); // R4
    AST_HI_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_LAT_HI && !expire |=> !irq_flag); // R3

endmodule

// File: tb/tb_reload_timer.sv
`timescale 1ns/1ps
module tb_reload_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, cont_mode = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, flag_clr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_flag, flag_set;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    reload_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cont_mode(cont_mode),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .flag_clr(flag_clr), .irq_flag(irq_flag), .flag_set(flag_set)
    );

    // {is_read, addr[1:0], wdata[7:0], expected[7:0]}
    localparam int NV = 13;
    localparam logic [18:0] VEC [0:NV-1] = '{
        {1'b0, 2'd2, 8'h34, 8'h00},   // R1 latch low
        {1'b0, 2'd3, 8'h12, 8'h00},   // R3 latch high
        {1'b1, 2'd2, 8'h00, 8'h34},   // R5
        {1'b1, 2'd3, 8'h00, 8'h12},   // R5
        {1'b0, 2'd1, 8'h56, 8'h00},   // R2 load 0x5634
        {1'b1, 2'd0, 8'h00, 8'h34},   // R4
        {1'b1, 2'd1, 8'h00, 8'h56},   // R4
        {1'b0, 2'd0, 8'h78, 8'h00},   // R1
        {1'b1, 2'd2, 8'h00, 8'h78},   // R1
        {1'b1, 2'd0, 8'h00, 8'h34},   // R1 count untouched
        {1'b0, 2'd3, 8'h9A, 8'h00},   // R3
        {1'b1, 2'd3, 8'h00, 8'h9A},   // R3
        {1'b1, 2'd1, 8'h00, 8'h56}    // R3 count untouched
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic tick1(output logic p);
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0; p = flag_set;
    endtask

    task automatic ticks(input int n);
        logic p;
        for (int i = 0; i < n; i++) tick1(p);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic p;
        int first_p, second_p, npulse;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 rdata", rdata, 0);
        check("R10 irq_flag", irq_flag, 0);
        check("R10 flag_set", flag_set, 0);
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), d);
            check("R10 reset byte", d, 8'hFF);
        end

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][18]) begin
                bus_read(VEC[v][17:16], d);
                check("R1/R2/R3/R4/R5 vector", d, VEC[v][7:0]);
            end else begin
                bus_write(VEC[v][17:16], VEC[v][15:8]);
            end
        end

        // R6 / R7 continuous period
        cont_mode = 1'b1;
        bus_write(2'd2, 8'h03);
        bus_write(2'd1, 8'h00);
        first_p = -1; second_p = -1;
        for (int t = 1; t <= 12; t++) begin
            tick1(p);
            if (p) begin
                if (first_p < 0) first_p = t; else if (second_p < 0) second_p = t;
            end
        end
        check("R7 first expiry tick", first_p, 4);
        check("R6 period", second_p - first_p, 5);
        check("R7 flag held", irq_flag, 1);
        bus_read(2'd1, d);
        check("R4 count hi", d, 8'h00);
        check("R4 hi read keeps flag", irq_flag, 1);
        bus_read(2'd0, d);
        check("R6 count after reload", d, 8'h01);
        check("R4 lo read clears flag", irq_flag, 0);

        // R6 sequence through 0xFFFF
        bus_write(2'd1, 8'h00);
        ticks(4);
        bus_read(2'd0, d); check("R6 wrap lo", d, 8'hFF);
        bus_read(2'd1, d); check("R6 wrap hi", d, 8'hFF);
        ticks(1);
        bus_read(2'd0, d); check("R6 reload value", d, 8'h03);

        // R11 hold without ticks
        repeat (10) @(negedge clk);
        bus_read(2'd0, d); check("R11 hold", d, 8'h03);

        // R9 latch change mid-period
        bus_write(2'd2, 8'h05);
        bus_write(2'd1, 8'h00);
        ticks(2);
        bus_write(2'd2, 8'h01);
        bus_read(2'd0, d); check("R1 lo write keeps count", d, 8'h03);
        bus_read(2'd2, d); check("R5 latch lo", d, 8'h01);
        ticks(5);
        bus_read(2'd0, d); check("R9 new latch used", d, 8'h01);
        bus_read(2'd1, d); check("R9 new latch hi", d, 8'h00);

        // R3 / R2 clear
        ticks(2);
        check("R7 flag up", irq_flag, 1);
        bus_write(2'd3, 8'h00);
        check("R3 clears flag", irq_flag, 0);
        bus_read(2'd0, d); check("R3 count untouched", d, 8'hFF);
        ticks(3);
        check("R7 flag up again", irq_flag, 1);
        bus_write(2'd1, 8'h00);
        check("R2 load clears flag", irq_flag, 0);

        // R12
        ticks(2);
        check("R7 flag before clr", irq_flag, 1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R12 clr input", irq_flag, 0);
        bus_write(2'd2, 8'h00);
        bus_write(2'd1, 8'h00);
        @(negedge clk); tick_en = 1'b1; flag_clr = 1'b1;
        @(negedge clk); tick_en = 1'b0; flag_clr = 1'b0;
        check("R12 set wins", irq_flag, 1);
        check("R7 pulse", flag_set, 1);
        @(negedge clk);
        check("R7 pulse one cycle", flag_set, 0);

        // R8 single shot
        cont_mode = 1'b0;
        bus_write(2'd2, 8'h02);
        bus_write(2'd1, 8'h00);
        ticks(2);
        tick1(p);
        check("R8 first expiry pulse", p, 1);
        bus_read(2'd1, d); check("R8 wrap hi", d, 8'hFF);
        ticks(1);
        bus_read(2'd0, d); check("R8 no reload lo", d, 8'hFE);
        check("R4 lo read clears", irq_flag, 0);
        npulse = 0;
        @(negedge clk); tick_en = 1'b1;
        for (int i = 0; i < 65540; i++) begin
            @(negedge clk);
            if (flag_set) npulse++;
        end
        tick_en = 1'b0;
        check("R8 no second expiry", npulse, 0);
        check("R8 flag stays low", irq_flag, 0);
        bus_read(2'd0, d); check("R8 keeps wrapping", d, 8'hFA);

        finish_run();
    end
endmodule